// File: doc/BRIEF.md
# Quad DAC Serial Register Front-End

This block is the digital control logic that sits in front of four current-output converters. A host writes a serial word on a three-wire link made of chip select, serial clock and serial data. Each word holds a two-bit channel address and one data code. When chip select rises, the code is written into the input register of the addressed channel. A second rank of four converter registers takes the input registers over while the active-low load strobe is low and holds them while it is high. Writes to several channels can therefore be staged and then released together, or the second rank can be left transparent for single-buffered use.

A preset input forces every register to zero-scale or half-scale, as chosen by a select pin. The power-on reset applies the same preset. A serial output repeats the incoming bit stream after a fixed number of serial clocks, so several blocks can be chained on one link.

The serial pins are expected to be synchronous to the system clock `clk` and slower than it. Serial clock and chip select edges are found by comparing each pin with its value one system clock earlier. The preset pin is sampled on every system clock edge.

Top module: `qdac_frontend`

## Requirements
- R1: A frame carries DW+2 bits, most significant first: two address bits, then the data code from its top bit down to bit 0. A bit is taken from `sdi` on each rising edge of `sclk` while `cs_n` is low.
- R2: While `cs_n` is high, rising edges of `sclk` shift nothing. The shift register keeps its contents, and a later frame with no clocks reloads the word it still holds.
- R3: On a rising edge of `cs_n`, only the last DW+2 bits shifted in are used. Extra leading bits, such as the padding in a three-byte frame for DW=16, are ignored.
- R4: The load writes the data code into the input register selected by the address: 00 selects channel A, 01 B, 10 C and 11 D. The other three input registers keep their values. Channel A appears on `dac_codes[DW-1:0]`, B on the next DW bits, then C, then D.
- R5: While `ldac_n` is high, the four converter registers hold. While it is low, they take their input register values. A load made while `ldac_n` is low reaches `dac_codes` on the same clock edge that writes the input register.
- R6: While `rs_n` is low, all input and converter registers are forced to the preset value: 0 when `preset_half` is 0, and 2^(DW-1) (0x8000 for DW=16) when it is 1. The preset wins over a load and over `ldac_n` in the same cycle.
- R7: `rst` (power-on reset, synchronous, active high) applies the same preset chosen by `preset_half` and clears the shift register. The registers keep the preset until a serial load and a converter update occur.
- R8: `sdo` presents the bit that was on `sdi` DW+3 shifting edges earlier (19 for DW=16). It advances only on `sclk` rising edges while `cs_n` is low, and it holds while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| cs_n | input | 1 | Chip select, active low; its rising edge loads the word |
| sclk | input | 1 | Serial clock; data is shifted on its rising edge |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out for chaining |
| ldac_n | input | 1 | Converter register load, level-sensitive, active low |
| rs_n | input | 1 | Preset, active low |
| preset_half | input | 1 | Preset select: 0 gives zero-scale, 1 gives half-scale |
| dac_codes | output | 4*DW | Converter register values, channel A in the low bits |

## Verification
The main load path is tried with exact-length frames to all four addresses, using codes with distinct bit patterns, so that a swapped address decode or a reversed bit order shows up in a wrong channel or a wrong value. Overlong frames with leading padding separate a design that keeps only the last DW+2 bits from one that keeps the first. Loads are made with `ldac_n` held low and again with it high and then pulsed, which tells a transparent second rank apart from a holding one. Preset tests use both select values, a preset that coincides with a chip-select edge, and a zero-length frame after clocks sent with `cs_n` high; together these show preset priority and that the shift register is frozen outside a frame. A bit-by-bit comparison of `sdo` checks the chain delay.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    localparam int NUM_CH = 4;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        CH_A = 2'd0,
        CH_B = 2'd1,
        CH_C = 2'd2,
        CH_D = 2'd3
    } chan_e;

    typedef enum logic {
        PRESET_ZERO = 1'b0,
        PRESET_HALF = 1'b1
    } preset_e;

    function automatic logic [NUM_CH-1:0] chan_select(input chan_e ch, input logic en);
        logic [NUM_CH-1:0] sel;
        sel = '0;
        if (en) sel[ch] = 1'b1;
        return sel;
    endfunction

endpackage

// File: rtl/qdac_serial_rx.sv
module qdac_serial_rx
    import qdac_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              load_stb,
    output chan_e             load_addr,
    output logic [DW-1:0]     load_data,
    output logic              sdo
);
    localparam int WORD_W = DW + ADDR_W;
    localparam int DEPTH  = WORD_W + 1;

    logic [DEPTH-1:0] sreg;
    logic             cs_q;
    logic             sclk_q;
    logic             shift_en;

    assign shift_en = sclk & ~sclk_q & ~cs_n;
    assign load_stb = cs_n & ~cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
            sreg   <= '0;
        end else begin
            cs_q   <= cs_n;
            sclk_q <= sclk;
            if (shift_en) sreg <= {sreg[DEPTH-2:0], sdi};
        end
    end

    assign load_addr = chan_e'(sreg[WORD_W-1 -: ADDR_W]);
    assign load_data = sreg[DW-1:0];
    assign sdo       = sreg[DEPTH-1];

    // R1: a shifting edge takes the sampled bit into the bottom stage
    a_r1_sample: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> sreg[0] == $past(sdi));

    // R2, R8: with chip select high the register and sdo are frozen
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> $stable(sreg));

    a_r8_sdo_hold: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(sdo));

endmodule

// File: rtl/qdac_chan_decode.sv
module qdac_chan_decode
    import qdac_pkg::*;
(
    input  chan_e             addr,
    input  logic              en,
    output logic [NUM_CH-1:0] wr_en
);
    always_comb begin
        wr_en = chan_select(addr, en);
    end
endmodule

// File: rtl/qdac_chan_reg.sv
module qdac_chan_reg #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          force_preset,
    input  logic [DW-1:0] preset_val,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          ldac_n,
    output logic [DW-1:0] code
);
    logic [DW-1:0] in_q;
    logic [DW-1:0] in_d;
    logic [DW-1:0] dac_q;

    always_comb begin
        in_d = wr_en ? wr_data : in_q;
    end

    always_ff @(posedge clk) begin
        if (force_preset) begin
            in_q  <= preset_val;
            dac_q <= preset_val;
        end else begin
            in_q <= in_d;
            if (!ldac_n) dac_q <= in_d;
        end
    end

    assign code = dac_q;

    // R6: preset lands in both ranks
    a_r6_preset: assert property (@(posedge clk) disable iff (rst)
        force_preset |=> (in_q == $past(preset_val)) && (dac_q == $past(preset_val)));

    // R4: an unselected input register keeps its value
    a_r4_keep: assert property (@(posedge clk) disable iff (rst)
        (!force_preset && !wr_en) |=> $stable(in_q));

    // R5: converter register holds while the strobe is high
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!force_preset && ldac_n) |=> $stable(dac_q));

    // R5: converter register matches the input rank while transparent
    a_r5_follow: assert property (@(posedge clk) disable iff (rst)
        (!force_preset && !ldac_n) |=> dac_q == in_q);

endmodule

// File: rtl/qdac_frontend.sv
module qdac_frontend
    import qdac_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             sdi,
    output logic             sdo,
    input  logic             ldac_n,
    input  logic             rs_n,
    input  logic             preset_half,
    output logic [4*DW-1:0]  dac_codes
);
    localparam logic [DW-1:0] HALF_CODE = DW'(1) << (DW - 1);

    logic              load_stb;
    chan_e             load_addr;
    logic [DW-1:0]     load_data;
    logic [NUM_CH-1:0] wr_en;
    logic [DW-1:0]     preset_val;
    logic              force_preset;
    preset_e           preset_mode;

    assign preset_mode  = preset_e'(preset_half);
    assign preset_val   = (preset_mode == PRESET_HALF) ? HALF_CODE : '0;
    assign force_preset = rst | ~rs_n;

    qdac_serial_rx #(.DW(DW)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sdi       (sdi),
        .load_stb  (load_stb),
        .load_addr (load_addr),
        .load_data (load_data),
        .sdo       (sdo)
    );

    qdac_chan_decode u_dec (
        .addr  (load_addr),
        .en    (load_stb),
        .wr_en (wr_en)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        qdac_chan_reg #(.DW(DW)) u_reg (
            .clk          (clk),
            .rst          (rst),
            .force_preset (force_preset),
            .preset_val   (preset_val),
            .wr_en        (wr_en[ch]),
            .wr_data      (load_data),
            .ldac_n       (ldac_n),
            .code         (dac_codes[ch*DW +: DW])
        );
    end

    // R4: a load selects exactly one channel
    a_r4_single: assert property (@(posedge clk) disable iff (rst)
        load_stb |-> $onehot(wr_en));

    // R4: no channel is written outside a load
    a_r4_idle: assert property (@(posedge clk) disable iff (rst)
        !load_stb |-> (wr_en == '0));

endmodule

// File: tb/test_qdac_frontend.sv
module test_qdac_frontend;
    localparam int DW    = 16;
    localparam int DELAY = DW + 3;
    localparam int NV    = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic ldac_n = 1'b0, rs_n = 1'b1, preset_half = 1'b0;
    logic sdo;
    logic [4*DW-1:0] dac_codes;

    int checks = 0, fails = 0, cycles = 0;
    logic [DW-1:0] exp_in [4];
    logic [DW-1:0] exp_dac[4];

    localparam int          TV_CH  [NV] = '{0, 1, 2, 3, 0, 2};
    localparam logic [15:0] TV_DATA[NV] = '{16'h1234, 16'hBEEF, 16'h0001, 16'hFFFF, 16'h8001, 16'h7E5A};
    localparam int          TV_LEAD[NV] = '{0, 0, 6, 0, 6, 3};

    qdac_frontend #(.DW(DW)) i_qdac_frontend (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo),
        .ldac_n(ldac_n), .rs_n(rs_n), .preset_half(preset_half), .dac_codes(dac_codes)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL all: watchdog expired, actual %0d cycles expected fewer", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic chk_all(input string req);
        for (int c = 0; c < 4; c++)
            chk(req, 64'(dac_codes[c*DW +: DW]), 64'(exp_dac[c]));
    endtask

    task automatic sbit(input logic b);
        sdi = b; sclk = 1'b0; idle(2);
        sclk = 1'b1; idle(2);
        sclk = 1'b0;
    endtask

    task automatic frame_bits(input int ch, input logic [DW-1:0] d, input int lead);
        cs_n = 1'b0; idle(2);
        for (int i = 0; i < lead; i++) sbit(~i[0]);
        sbit(ch[1]); sbit(ch[0]);
        for (int i = DW - 1; i >= 0; i--) sbit(d[i]);
        idle(1);
    endtask

    task automatic send(input int ch, input logic [DW-1:0] d, input int lead);
        frame_bits(ch, d, lead);
        cs_n = 1'b1; idle(3);
        exp_in[ch] = d;
        if (!ldac_n) for (int c = 0; c < 4; c++) exp_dac[c] = exp_in[c];
    endtask

    task automatic set_model(input logic [DW-1:0] v);
        for (int c = 0; c < 4; c++) begin exp_in[c] = v; exp_dac[c] = v; end
    endtask

    logic hist[64];

    initial begin
        // R7: power-on reset to zero-scale
        preset_half = 1'b0; idle(3); rst = 1'b0; idle(1);
        set_model('0);
        chk_all("R7 reset zero");

        // R1 R3 R4 R5: table walk with the strobe held low
        ldac_n = 1'b0;
        for (int v = 0; v < NV; v++) begin
            send(TV_CH[v], TV_DATA[v], TV_LEAD[v]);
            chk_all(TV_LEAD[v] == 0 ? "R1 R4 exact frame" : "R3 R4 padded frame");
        end

        // R5: strobe high holds, then a pulse releases
        ldac_n = 1'b1; idle(1);
        send(1, 16'h5555, 0);
        chk_all("R5 hold while high");
        ldac_n = 1'b0; idle(2); ldac_n = 1'b1; idle(1);
        for (int c = 0; c < 4; c++) exp_dac[c] = exp_in[c];
        chk_all("R5 pulse update");

        // R6 zero-scale, then R2 frozen shift register reloads its old word
        rs_n = 1'b0; idle(2); rs_n = 1'b1; idle(1);
        set_model('0);
        chk_all("R6 preset zero");
        for (int i = 0; i < 5; i++) sbit(1'b1);
        cs_n = 1'b0; idle(3); cs_n = 1'b1; idle(3);
        exp_in[1] = 16'h5555;
        chk_all("R2 no change before strobe");
        ldac_n = 1'b0; idle(2);
        exp_dac[1] = 16'h5555;
        chk_all("R2 empty frame reloads held word");

        // R6 half-scale wins over a load in the same cycle
        preset_half = 1'b1;
        frame_bits(3, 16'h0F0F, 0);
        rs_n = 1'b0; cs_n = 1'b1; idle(2); rs_n = 1'b1; idle(1);
        set_model(16'h8000);
        chk_all("R6 preset half over load");

        // R7 power-on reset with half-scale select
        rst = 1'b1; idle(2); rst = 1'b0; idle(1);
        chk_all("R7 reset half");

        // R8 daisy-chain delay, after reset clears the line
        preset_half = 1'b0;
        rst = 1'b1; idle(2); rst = 1'b0; idle(1);
        cs_n = 1'b0; idle(2);
        for (int k = 0; k < 40; k++) begin
            logic b;
            b = k[0] ^ k[2] ^ (k > 20);
            hist[k] = b;
            sbit(b);
            chk("R8 sdo delay", 64'(sdo), 64'(k + 1 >= DELAY ? hist[k + 1 - DELAY] : 1'b0));
        end
        cs_n = 1'b1; idle(3);
        for (int i = 0; i < 4; i++) sbit(~hist[40 - DELAY + i]);
        chk("R8 sdo holds with cs high", 64'(sdo), 64'(hist[40 - DELAY]));

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule